// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a synchronous host and an 8-bit extended-data-out asynchronous DRAM. It sequences the row and column address strobes, the write strobe and the output enable. It places the row and column halves of the request address on one shared address bus. A request arrives through a valid/ready handshake. A read returns its byte on `rsp_rdata` with a one-cycle strobe. A write uses the early-write form: the write strobe goes low before the column strobe falls, and the controller drives the data bus for that column.

Every timing limit is a nanosecond parameter. The controller turns each one into a cycle count by rounding `T/CLK_NS` upward. While a row is open, a following request with the same row and the same direction joins the open row as another column cycle of a page burst. The burst goes on only if the column still fits inside the maximum row-open time. A separate refresh block raises `refresh_grant` to stop new accesses from starting.

Top module: `edo_dram_ctrl`

## Requirements
- R1: During and after reset, with no request pending, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1 while `refresh_grant` is 0.
- R2: Address split: the row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. When the row strobe falls, `dram_addr` holds the row. When the column strobe falls, it holds the column, zero-extended.
- R3: A read returns the byte stored at the addressed row and column on `rsp_rdata`, together with a `rsp_valid` pulse one cycle long. The byte is sampled only after the column strobe has been low for ceil(T_CAC_NS/CLK_NS) full cycles.
- R4: Early write: in the cycle before the column strobe falls, `dram_we_n` is already 0. At the fall, `dram_dq_oe` is 1 and `dram_dq_out` carries the write byte. `dram_oe_n` stays 1.
- R5: While the column strobe is low in a read, `dram_oe_n` is 0, `dram_we_n` is 1 and `dram_dq_oe` is 0. The column strobe is never low while the row strobe is high.
- R6: A request accepted while a row is open, with the same row and the same direction (read or write), is served without a new fall of the row strobe.
- R7: A request with a different row, or the opposite direction, closes the open row. The request then starts with a new fall of the row strobe.
- R8: Timing: the row strobe is high for at least ceil(T_RP_NS/CLK_NS)+1 cycles before it falls again. The column strobe falls at least ceil(T_RCD_NS/CLK_NS)+1 cycles after the row strobe falls. Between burst columns, the column strobe is high for at least ceil(T_CP_NS/CLK_NS)+1 cycles. A write holds the column strobe low for at least ceil(T_CASW_NS/CLK_NS) cycles. The row strobe stays low for at least ceil(T_RAS_NS/CLK_NS) cycles.
- R9: While `refresh_grant` is 1, `req_ready` is 0 and the row strobe does not fall for a new access.
- R10: After a read closes its row, `dram_dq_oe` does not rise until at least ceil(T_OFF_NS/CLK_NS) cycles after the row strobe has risen.
- R11: The row strobe is never low for more than ceil(T_RASP_NS/CLK_NS) cycles. A burst column that would not fit in that window closes the row instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_grant | input | 1 | Refresh owns the memory; hold off new accesses |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row bits above column bits |
| req_wdata | input | DQ_W | Write byte |
| rsp_valid | output | 1 | Read byte valid, one-cycle pulse |
| rsp_rdata | output | DQ_W | Read byte |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed memory address |
| dram_ras_n | output | 1 | Row address strobe, active low |
| dram_cas_n | output | 1 | Column address strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DQ_W | Data driven toward memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DQ_W | Data returned by memory |

## Verification
A wrong internal state shows up at the strobe pins within one column cycle. A sequencer stuck in the wrong phase gives a column strobe fall with too little row-to-column delay. It can also give a write strobe that was not set up ahead of the column edge, or an extra or missing row strobe fall in a burst. A miscounted access wait makes the sampled byte the memory model's "not yet valid" filler, and that mismatch appears on the next `rsp_valid` pulse. A wrong burst-window count shows as a row strobe low time above the limit, or as one fall too many across three same-row reads.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CASLO,
        ST_CAP,
        ST_CASHI
    } edo_st_e;

    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_req_split.sv
module edo_req_split #(
    parameter int ROW_W = 13,
    parameter int COL_W = 10
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col
);
    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int AW    = 13
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             sel_col,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] row_ext;
    logic [AW-1:0] col_ext;

    generate
        if (ROW_W == AW) begin : g_row_full
            assign row_ext = row;
        end else begin : g_row_pad
            assign row_ext = {{(AW-ROW_W){1'b0}}, row};
        end
        if (COL_W == AW) begin : g_col_full
            assign col_ext = col;
        end else begin : g_col_pad
            assign col_ext = {{(AW-COL_W){1'b0}}, col};
        end
    endgenerate

    assign addr = sel_col ? col_ext : row_ext;
endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
    parameter int N_RASP = 50000,
    parameter int N_RAS  = 13,
    parameter int COLCYC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic room,
    output logic min_met
);
    localparam int RW = $clog2(N_RASP + COLCYC + 2);

    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!ras_low)           cnt_d = '0;
        else if (cnt_q != '1)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign room    = (32'(cnt_q) + 32'(COLCYC) + 32'd1) <= 32'(N_RASP);
    assign min_met = (32'(cnt_q) + 32'd1) >= 32'(N_RAS);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int CLK_NS    = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int DQ_W      = 8,
    parameter int T_RP_NS   = 30,
    parameter int T_RCD_NS  = 20,
    parameter int T_CAC_NS  = 13,
    parameter int T_CASW_NS = 8,
    parameter int T_CP_NS   = 10,
    parameter int T_RAS_NS  = 50,
    parameter int T_RASP_NS = 200000,
    parameter int T_OFF_NS  = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   refresh_grant,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rsp_valid,
    output logic [DQ_W-1:0]        rsp_rdata,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);
    localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int N_RP    = ns2cyc(T_RP_NS, CLK_NS);
    localparam int N_RCD   = ns2cyc(T_RCD_NS, CLK_NS);
    localparam int N_CAC   = ns2cyc(T_CAC_NS, CLK_NS);
    localparam int N_CASW  = ns2cyc(T_CASW_NS, CLK_NS);
    localparam int N_CP    = ns2cyc(T_CP_NS, CLK_NS);
    localparam int N_RAS   = ns2cyc(T_RAS_NS, CLK_NS);
    localparam int N_RASP  = ns2cyc(T_RASP_NS, CLK_NS);
    localparam int N_OFF   = ns2cyc(T_OFF_NS, CLK_NS);
    localparam int N_PRERD = imax(N_RP, N_OFF);
    localparam int COLCYC  = 2 + imax(N_CAC, N_CASW) + N_CP;
    localparam int N_MAX   = imax(imax(imax(N_RCD, N_CAC), imax(N_CASW, N_CP)), N_PRERD);
    localparam int TW      = $clog2(N_MAX + 1);

    typedef struct packed {
        edo_st_e          st;
        logic [TW-1:0]    tmr;
        logic [TW-1:0]    pre;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic [DQ_W-1:0]  wdata;
        logic [DQ_W-1:0]  rdata;
        logic             rsp;
    } ctl_t;

    ctl_t q, d;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             ras_low, room, min_met, accept, same_open, sel_col;

    edo_req_split #(.ROW_W(ROW_W), .COL_W(COL_W)) split_i (
        .addr(req_addr), .row(req_row), .col(req_col)
    );

    edo_ras_window #(.N_RASP(N_RASP), .N_RAS(N_RAS), .COLCYC(COLCYC)) win_i (
        .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .room(room), .min_met(min_met)
    );

    assign sel_col = (q.st == ST_COL) || (q.st == ST_CASLO) ||
                     (q.st == ST_CAP) || (q.st == ST_CASHI);

    edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) amux_i (
        .row(q.row), .col(q.col), .sel_col(sel_col), .addr(dram_addr)
    );

    assign ras_low   = (q.st != ST_IDLE) && (q.st != ST_ROW);
    assign same_open = (req_row == q.row) && (req_write == q.wr);
    assign req_ready = !refresh_grant &&
                       (((q.st == ST_IDLE) && (q.pre == '0)) ||
                        ((q.st == ST_CASHI) && (q.tmr == '0) && room && same_open));
    assign accept    = req_valid && req_ready;

    always_comb begin
        d     = q;
        d.rsp = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (q.pre != '0) d.pre = q.pre - 1'b1;
                if (accept) begin
                    d.st    = ST_ROW;
                    d.row   = req_row;
                    d.col   = req_col;
                    d.wr    = req_write;
                    d.wdata = req_wdata;
                end
            end
            ST_ROW: begin
                d.st  = ST_RCD;
                d.tmr = TW'(N_RCD - 1);
            end
            ST_RCD: begin
                if (q.tmr == '0) d.st  = ST_COL;
                else             d.tmr = q.tmr - 1'b1;
            end
            ST_COL: begin
                d.st  = ST_CASLO;
                d.tmr = q.wr ? TW'(N_CASW - 1) : TW'(N_CAC - 1);
            end
            ST_CASLO: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (q.wr) begin
                    d.st  = ST_CASHI;
                    d.tmr = TW'(N_CP - 1);
                end else begin
                    d.st = ST_CAP;
                end
            end
            ST_CAP: begin
                d.rdata = dram_dq_in;
                d.rsp   = 1'b1;
                d.st    = ST_CASHI;
                d.tmr   = TW'(N_CP - 1);
            end
            ST_CASHI: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (accept) begin
                    d.st    = ST_COL;
                    d.col   = req_col;
                    d.wdata = req_wdata;
                end else if (min_met) begin
                    d.st  = ST_IDLE;
                    d.pre = q.wr ? TW'(N_RP - 1) : TW'(N_PRERD - 1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.tmr   <= '0;
            q.pre   <= '0;
            q.row   <= '0;
            q.col   <= '0;
            q.wr    <= 1'b0;
            q.wdata <= '0;
            q.rdata <= '0;
            q.rsp   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dram_ras_n  = !ras_low;
    assign dram_cas_n  = !((q.st == ST_CASLO) || (q.st == ST_CAP));
    assign dram_we_n   = !(q.wr && ((q.st == ST_COL) || (q.st == ST_CASLO)));
    assign dram_oe_n   = !(!q.wr && ras_low);
    assign dram_dq_oe  = q.wr && ((q.st == ST_COL) || (q.st == ST_CASLO));
    assign dram_dq_out = q.wdata;
    assign rsp_valid   = q.rsp;
    assign rsp_rdata   = q.rdata;
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic refresh_grant,
    input logic req_ready,
    input logic rsp_valid,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_grant |-> !req_ready);

    // R5
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R4
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    // R5
    oe_vs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    // R10
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n));

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    cas_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dram_cas_n) && !dram_ras_n) |=> dram_cas_n);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .refresh_grant(refresh_grant), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;
    localparam int CLK = 4;
    localparam int RW  = 13;
    localparam int CW  = 10;
    localparam int AW  = 13;

    function automatic int cyc(input int ns);
        return (ns + CLK - 1) / CLK;
    endfunction

    localparam int E_RP   = cyc(30);
    localparam int E_RCD  = cyc(20);
    localparam int E_CAC  = cyc(13);
    localparam int E_CASW = cyc(8);
    localparam int E_CP   = cyc(10);
    localparam int E_RAS  = cyc(50);
    localparam int E_RASP = cyc(100);
    localparam int E_OFF  = cyc(13);

    logic clk = 0;
    logic rst_n = 0;
    logic refresh_grant = 0;
    logic req_valid = 0, req_write = 0;
    logic req_ready;
    logic [RW+CW-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic rsp_valid;
    logic [7:0] rsp_rdata;
    logic [AW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [7:0] dram_dq_out;
    logic [7:0] dram_dq_in = 8'hEE;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK/2) clk = ~clk;

    edo_dram_ctrl #(.CLK_NS(CLK), .ROW_W(RW), .COL_W(CW), .T_RASP_NS(100)) dut_i (
        .clk(clk), .rst_n(rst_n), .refresh_grant(refresh_grant),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model, evaluated away from the active edge
    logic [7:0]    mem [256];
    logic [AW-1:0] row_l, col_l;
    logic          ras_p = 1, cas_p = 1, we_p = 1, dqoe_p = 0;
    logic          first_col = 0, rise_seen = 0, cas_wr = 0, last_rd = 0;
    int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0, off_cnt = 0, ras_falls = 0;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_ras_n && !ras_p) begin
                check(ras_lo >= E_RAS, "R8 ras low min", ras_lo, E_RAS);
                check(ras_lo <= E_RASP, "R11 ras low max", ras_lo, E_RASP);
                ras_hi = 1; off_cnt = 1; rise_seen = 1;
            end else if (dram_ras_n) begin
                ras_hi++; off_cnt++;
            end
            if (!dram_ras_n && ras_p) begin
                if (rise_seen) check(ras_hi >= E_RP + 1, "R8 ras precharge", ras_hi, E_RP + 1);
                row_l = dram_addr; ras_lo = 1; ras_falls++; first_col = 1;
            end else if (!dram_ras_n) begin
                ras_lo++;
            end
            if (!dram_cas_n && cas_p) begin
                if (first_col) check(ras_lo - 1 >= E_RCD + 1, "R8 ras to cas", ras_lo - 1, E_RCD + 1);
                else           check(cas_hi >= E_CP + 1, "R8 cas precharge", cas_hi, E_CP + 1);
                first_col = 0;
                col_l = dram_addr; cas_lo = 1; cas_wr = !dram_we_n;
                if (!dram_we_n) begin
                    check(!we_p && dram_dq_oe && dram_oe_n, "R4 early write", int'(we_p), 0);
                    mem[{row_l[3:0], col_l[3:0]}] = dram_dq_out;
                    last_rd = 0;
                end else begin
                    check(!dram_oe_n && !dram_dq_oe, "R5 read strobes", int'(dram_dq_oe), 0);
                    last_rd = 1;
                end
            end else if (!dram_cas_n) begin
                cas_lo++;
            end
            if (dram_cas_n && !cas_p) begin
                if (cas_wr) check(cas_lo >= E_CASW, "R8 write cas width", cas_lo, E_CASW);
                cas_hi = 1;
            end else if (dram_cas_n) begin
                cas_hi++;
            end
            if (dram_dq_oe && !dqoe_p && last_rd)
                check(off_cnt >= E_OFF, "R10 turnaround", off_cnt, E_OFF);
            dram_dq_in = (!dram_cas_n && !dram_oe_n && dram_we_n && cas_lo > E_CAC)
                         ? mem[{row_l[3:0], col_l[3:0]}] : 8'hEE;
        end
        ras_p = dram_ras_n; cas_p = dram_cas_n; we_p = dram_we_n; dqoe_p = dram_dq_oe;
    end

    logic [7:0] rsp_buf [16];
    int rsp_n = 0;
    always @(negedge clk) if (rst_n && rsp_valid) begin
        rsp_buf[rsp_n % 16] = rsp_rdata;
        rsp_n++;
    end

    function automatic logic [RW+CW-1:0] mk(input int r, input int c);
        return {RW'(r), CW'(c)};
    endfunction

    function automatic logic [7:0] init_val(input int r, input int c);
        return 8'({r[3:0], c[3:0]}) ^ 8'h5A;
    endfunction

    task automatic send(input logic wr, input logic [RW+CW-1:0] a, input logic [7:0] dat);
        req_write = wr; req_addr = a; req_wdata = dat; req_valid = 1; #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_rsp(input int n);
        int t = 0;
        while (rsp_n < n && t < 300) begin @(negedge clk); t++; end
    endtask

    task automatic settle();
        repeat (24) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset", 0, 1);
        rst_n = 1;
        @(negedge clk); #1;
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid,
              "R1 idle outputs", int'(dram_dq_oe), 0);
        check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_write_read();
        int n0;
        send(1, mk(13'h1ABC, 10'h2C3), 8'hA7);
        settle();
        check(row_l == AW'(13'h1ABC), "R2 row address", int'(row_l), 13'h1ABC);
        check(col_l == AW'(10'h2C3), "R2 column address", int'(col_l), 10'h2C3);
        n0 = rsp_n;
        send(0, mk(13'h1ABC, 10'h2C3), 8'h00);
        wait_rsp(n0 + 1);
        check(rsp_n == n0 + 1, "R3 one response", rsp_n - n0, 1);
        check(rsp_buf[n0 % 16] == 8'hA7, "R3 read back", int'(rsp_buf[n0 % 16]), 8'hA7);
        settle();
        n0 = rsp_n;
        send(0, mk(5, 9), 8'h00);
        wait_rsp(n0 + 1);
        check(rsp_buf[n0 % 16] == init_val(5, 9), "R3 untouched cell",
              int'(rsp_buf[n0 % 16]), int'(init_val(5, 9)));
        settle();
    endtask

    task automatic t_burst();
        int f0, n0;
        f0 = ras_falls;
        send(1, mk(7, 1), 8'h11);
        send(1, mk(7, 2), 8'h22);
        settle();
        check(ras_falls - f0 == 1, "R6 write burst one row open", ras_falls - f0, 1);
        f0 = ras_falls; n0 = rsp_n;
        send(0, mk(7, 1), 8'h00);
        send(0, mk(7, 2), 8'h00);
        wait_rsp(n0 + 2);
        settle();
        check(ras_falls - f0 == 1, "R6 read burst one row open", ras_falls - f0, 1);
        check(rsp_buf[n0 % 16] == 8'h11, "R6 burst first byte", int'(rsp_buf[n0 % 16]), 8'h11);
        check(rsp_buf[(n0 + 1) % 16] == 8'h22, "R6 burst second byte",
              int'(rsp_buf[(n0 + 1) % 16]), 8'h22);
    endtask

    task automatic t_close();
        int f0, n0;
        f0 = ras_falls; n0 = rsp_n;
        send(0, mk(2, 3), 8'h00);
        send(0, mk(3, 3), 8'h00);
        wait_rsp(n0 + 2);
        settle();
        check(ras_falls - f0 == 2, "R7 row change reopens", ras_falls - f0, 2);
        check(rsp_buf[(n0 + 1) % 16] == init_val(3, 3), "R7 second row data",
              int'(rsp_buf[(n0 + 1) % 16]), int'(init_val(3, 3)));
        f0 = ras_falls; n0 = rsp_n;
        send(0, mk(4, 6), 8'h00);
        send(1, mk(4, 6), 8'h3C);
        settle();
        check(ras_falls - f0 == 2, "R7 direction change reopens", ras_falls - f0, 2);
        send(0, mk(4, 6), 8'h00);
        wait_rsp(n0 + 2);
        check(rsp_buf[(n0 + 1) % 16] == 8'h3C, "R10 write after read lands",
              int'(rsp_buf[(n0 + 1) % 16]), 8'h3C);
        settle();
    endtask

    task automatic t_window();
        int f0, n0;
        f0 = ras_falls; n0 = rsp_n;
        send(0, mk(9, 1), 8'h00);
        send(0, mk(9, 2), 8'h00);
        send(0, mk(9, 3), 8'h00);
        wait_rsp(n0 + 3);
        settle();
        check(ras_falls - f0 == 2, "R11 window forces close", ras_falls - f0, 2);
        check(rsp_buf[(n0 + 2) % 16] == init_val(9, 3), "R11 third byte",
              int'(rsp_buf[(n0 + 2) % 16]), int'(init_val(9, 3)));
    endtask

    task automatic t_refresh();
        int f0, seen;
        f0 = ras_falls; seen = 0;
        refresh_grant = 1;
        req_write = 0; req_addr = mk(6, 6); req_valid = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (req_ready) seen++;
        end
        check(seen == 0, "R9 ready held low", seen, 0);
        check(ras_falls == f0, "R9 no row opened", ras_falls - f0, 0);
        refresh_grant = 0;
        req_valid = 0;
        send(0, mk(6, 6), 8'h00);
        settle();
        check(ras_falls - f0 == 1, "R9 access after grant drops", ras_falls - f0, 1);
    endtask

    initial begin
        #(200000 * CLK);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write_read();
        t_burst();
        t_close();
        t_window();
        t_refresh();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule